// File: doc/BRIEF.md
# Three-Wire Serial Memory Protocol Engine

This block lets a host reach a byte-wide static RAM through a three-wire serial link. The three wires are a select line, a serial clock and one data line that both ends can drive. A level-high select opens a transaction. The host first shifts in a seven-byte header. The engine decodes that header and then runs one of these actions:
- a burst read or a burst write with automatic address advance,
- a read-back or update of the 16-bit device identity,
- a read of the check value that an external CRC unit holds,
- a masked identity search read.

The engine drives the RAM strobes, address and write data itself. A drive-enable output tells the far end when the engine owns the data line.

The serial inputs arrive synchronously to the system clock, and the engine finds the serial clock edges by comparing the current serial clock with its value one system clock earlier. The CRC arithmetic is not done here. An external unit reports whether the header's check byte was correct (`hdr_crc_ok`, sampled when the last header bit has arrived) and supplies the stored check value (`crc_value`).

Top module: `tw_serial_mem`

## Requirements
- R1: After reset, `ram_ce_n`, `ram_oe_n` and `ram_we_n` are high, `ser_drive` is low and the stored identity is 0x0000.
- R2: While `ser_sel` is high, a data bit is taken on each rising serial clock edge. Output bits change only after falling serial clock edges. Every byte travels least significant bit first. The 56 header bits, in arrival order, are:
  - header[7:0]: the function byte,
  - header[23:8]: address bits 15..0,
  - header[26:24]: address bits 18..16,
  - header[31:27]: the command, with header[31] as command bit 4,
  - header[47:32]: the identity field,
  - header[55:48]: the check byte.
- R3: Function byte 0xE8 selects reading and 0x17 selects writing. Any other value gives no RAM access and no driving of the data line.
- R4: When `hdr_crc_ok` is low at the end of the header, nothing is done: no RAM access, no drive and no identity update.
- R5: Burst read (read function, command 00110) reads the addressed byte and shifts it out on the next eight falling edges with `ser_drive` high. Each further byte comes from the next address, and the address wraps from 0x7FFFF to 0x00000.
- R6: Burst write (write function, command 10001) proceeds only if the identity field equals the stored identity. The eighth rising edge of each byte is followed by a single-cycle write strobe, and then the address advances by one.
- R7: Taking `ser_sel` low abandons a byte that is only partly received, but a byte that is complete is still written.
- R8: Write-identity (write function, command 01110) loads the identity field into the stored identity. Read-identity (read function, command 00101) sends out the stored identity as 16 bits, least significant bit first, and then releases the data line at the next falling edge.
- R9: Read-check (read function, command 00011) sends out `crc_value` on eight falling edges and then releases the data line at the next falling edge.
- R10: Masked read (read function, command 11kkk) compares only the 2×kkk lowest identity bits. On a match it acts as a burst read; otherwise nothing is done.
- R11: `ser_drive` is low whenever the engine is not sending, and it goes low one cycle after `ser_sel` falls. Other command codes, including the arbitration codes 10110 and 01001, do nothing.
- R12: `ram_oe_n` and `ram_we_n` are never low together. Each of them is low only for a single cycle, and only while `ram_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel | input | 1 | Serial transaction select, active high |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host |
| ser_drive | output | 1 | High while the engine drives the data line |
| hdr_crc_ok | input | 1 | External CRC unit reports a good header check byte |
| crc_value | input | 8 | Stored check value from the external CRC unit |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_addr | output | 19 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
The header stimulus mixes valid and corrupted function bytes, good and bad check flags, matching and mismatching identities, and every command class. This separates the cases where the engine must act from those where it must stay silent. Bursts start at random addresses and directly at 0x7FFFF, which separates correct address advance and wrap from a stuck or unbounded counter. The masked search uses identities that agree only in the unmasked low bits, or that differ in exactly one of them, so it exposes a mask that is too wide or too narrow. A transaction cut off after twelve data bits shows whether complete and partial bytes are treated differently.

// File: rtl/tw_pkg.sv
package tw_pkg;
    parameter int ADDR_W    = 19;
    parameter int SEL_W     = 16;
    parameter int BYTE_W    = 8;
    parameter int HDR_BYTES = 7;
    localparam int HDR_W    = HDR_BYTES * BYTE_W;
    localparam int CMD_W    = 5;
    localparam int BITC_W   = $clog2(BYTE_W + 1);

    localparam logic [BYTE_W-1:0] FN_READ  = 8'hE8;
    localparam logic [BYTE_W-1:0] FN_WRITE = 8'h17;

    localparam logic [CMD_W-1:0] CMD_BURST_RD = 5'b00110;
    localparam logic [CMD_W-1:0] CMD_BURST_WR = 5'b10001;
    localparam logic [CMD_W-1:0] CMD_RD_CHECK = 5'b00011;
    localparam logic [CMD_W-1:0] CMD_RD_IDENT = 5'b00101;
    localparam logic [CMD_W-1:0] CMD_WR_IDENT = 5'b01110;

    // header as received, least significant field arrives first
    typedef struct packed {
        logic [BYTE_W-1:0]       chk;
        logic [SEL_W-1:0]        ident;
        logic [CMD_W-1:0]        cmd;
        logic [ADDR_W-17:0]      a_hi;
        logic [15:0]             a_lo;
        logic [BYTE_W-1:0]       fn;
    } hdr_t;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_RD_RAM, ACT_RD_CHECK, ACT_RD_IDENT, ACT_WR_RAM, ACT_WR_IDENT
    } act_e;

    typedef enum logic [2:0] {
        ST_HDR, ST_FETCH, ST_SEND, ST_RECV, ST_WSTROBE, ST_HOLD
    } st_e;

    typedef enum logic [1:0] { SRC_RAM, SRC_CHECK, SRC_IDENT } src_e;

    // identity bits compared by a masked read: two per step from the LSB
    function automatic logic [SEL_W-1:0] unmask_bits(logic [2:0] step);
        logic [SEL_W-1:0] m;
        m = '0;
        for (int i = 0; i < SEL_W / 2; i++)
            if (i < int'(step)) m[2*i +: 2] = 2'b11;
        return m;
    endfunction

    function automatic act_e decode_hdr(hdr_t h, logic [SEL_W-1:0] cur, logic ok);
        act_e a;
        a = ACT_NONE;
        if (ok) begin
            if (h.fn == FN_READ) begin
                if (h.cmd == CMD_BURST_RD)      a = ACT_RD_RAM;
                else if (h.cmd == CMD_RD_CHECK) a = ACT_RD_CHECK;
                else if (h.cmd == CMD_RD_IDENT) a = ACT_RD_IDENT;
                else if (h.cmd[4:3] == 2'b11 &&
                         ((h.ident ^ cur) & unmask_bits(h.cmd[2:0])) == '0)
                    a = ACT_RD_RAM;
            end else if (h.fn == FN_WRITE) begin
                if (h.cmd == CMD_BURST_WR && h.ident == cur) a = ACT_WR_RAM;
                else if (h.cmd == CMD_WR_IDENT)              a = ACT_WR_IDENT;
            end
        end
        return a;
    endfunction
endpackage

// File: rtl/tw_edge_det.sv
module tw_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= sig;
    end

    assign rise = sig & ~prev;
    assign fall = ~sig & prev;
endmodule

// File: rtl/tw_hdr_shift.sv
module tw_hdr_shift #(
    parameter int W = 56
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] hdr,
    output logic         full
);
    localparam int CW = $clog2(W + 1);
    logic [CW-1:0] cnt;

    assign full = (cnt == CW'(W));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && !full) begin
            hdr <= {din, hdr[W-1:1]};
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tw_ident_reg.sv
module tw_ident_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/tw_serial_mem.sv
module tw_serial_mem
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_drive,
    input  logic              hdr_crc_ok,
    input  logic [BYTE_W-1:0] crc_value,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    input  logic [BYTE_W-1:0] ram_rdata
);
    st_e               st;
    src_e              src;
    logic              rise, fall;
    logic [HDR_W-1:0]  hdr_bits;
    logic              hdr_full;
    hdr_t              hv;
    act_e              act;
    logic [SEL_W-1:0]  ident_q;
    logic              ident_load;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] tx_sh, rx_sh;
    logic [BITC_W-1:0] bitc;
    logic              half;

    tw_edge_det i_edge (
        .clk (clk), .rst (rst), .sig (ser_clk), .rise (rise), .fall (fall)
    );

    tw_hdr_shift #(.W(HDR_W)) i_hdr (
        .clk (clk), .rst (rst), .clr (!ser_sel),
        .en  (rise && ser_sel && st == ST_HDR),
        .din (ser_din), .hdr (hdr_bits), .full (hdr_full)
    );

    assign hv  = hdr_t'(hdr_bits);
    assign act = decode_hdr(hv, ident_q, hdr_crc_ok);
    assign ident_load = ser_sel && st == ST_HDR && hdr_full && act == ACT_WR_IDENT;

    tw_ident_reg #(.W(SEL_W)) i_ident (
        .clk (clk), .rst (rst), .load (ident_load), .d (hv.ident), .q (ident_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_HDR;
            src       <= SRC_RAM;
            addr      <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            bitc      <= '0;
            half      <= 1'b0;
            ser_dout  <= 1'b0;
            ser_drive <= 1'b0;
        end else if (!ser_sel && st != ST_WSTROBE) begin
            st        <= ST_HDR;
            bitc      <= '0;
            ser_drive <= 1'b0;
        end else begin
            case (st)
                ST_HDR: if (hdr_full) begin
                    addr <= {hv.a_hi, hv.a_lo};
                    bitc <= '0;
                    half <= 1'b0;
                    case (act)
                        ACT_RD_RAM:   begin src <= SRC_RAM;   st <= ST_FETCH; end
                        ACT_RD_CHECK: begin src <= SRC_CHECK; tx_sh <= crc_value;
                                            st <= ST_SEND; end
                        ACT_RD_IDENT: begin src <= SRC_IDENT; tx_sh <= ident_q[BYTE_W-1:0];
                                            st <= ST_SEND; end
                        ACT_WR_RAM:   st <= ST_RECV;
                        default:      st <= ST_HOLD;
                    endcase
                end
                ST_FETCH: begin
                    tx_sh <= ram_rdata;
                    bitc  <= '0;
                    st    <= ST_SEND;
                end
                ST_SEND: if (fall) begin
                    if (bitc == BITC_W'(BYTE_W)) begin
                        ser_drive <= 1'b0;
                        st        <= ST_HOLD;
                    end else begin
                        ser_dout  <= tx_sh[0];
                        tx_sh     <= tx_sh >> 1;
                        ser_drive <= 1'b1;
                        if (bitc == BITC_W'(BYTE_W - 1)) begin
                            case (src)
                                SRC_RAM: begin
                                    addr <= addr + 1'b1;
                                    st   <= ST_FETCH;
                                end
                                SRC_IDENT: if (!half) begin
                                    tx_sh <= ident_q[SEL_W-1:BYTE_W];
                                    half  <= 1'b1;
                                    bitc  <= '0;
                                end else begin
                                    bitc  <= BITC_W'(BYTE_W);
                                end
                                default: bitc <= BITC_W'(BYTE_W);
                            endcase
                        end else begin
                            bitc <= bitc + 1'b1;
                        end
                    end
                end
                ST_RECV: if (rise) begin
                    rx_sh <= {ser_din, rx_sh[BYTE_W-1:1]};
                    if (bitc == BITC_W'(BYTE_W - 1)) begin
                        bitc <= '0;
                        st   <= ST_WSTROBE;
                    end else begin
                        bitc <= bitc + 1'b1;
                    end
                end
                ST_WSTROBE: begin
                    addr <= addr + 1'b1;
                    st   <= ser_sel ? ST_RECV : ST_HDR;
                end
                default: ;
            endcase
        end
    end

    assign ram_ce_n  = !(st == ST_FETCH || st == ST_WSTROBE);
    assign ram_oe_n  = !(st == ST_FETCH);
    assign ram_we_n  = !(st == ST_WSTROBE);
    assign ram_addr  = addr;
    assign ram_wdata = rx_sh;
endmodule

// File: rtl/tw_checks.sv
module tw_checks
    import tw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ser_sel,
    input logic              ser_clk,
    input logic              ser_dout,
    input logic              ser_drive,
    input logic              ram_ce_n,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic [ADDR_W-1:0] ram_addr
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!ram_oe_n && !ram_we_n));                                   // R12
    AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (rst)
        (!ram_oe_n || !ram_we_n) |-> !ram_ce_n);                      // R12
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |=> ram_we_n);                                      // R6
    AST_OE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |=> ram_oe_n);                                      // R12
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |=> ram_addr == ADDR_W'($past(ram_addr) + 1'b1));   // R6
    AST_DROP_ON_DESEL: assert property (@(posedge clk) disable iff (rst)
        !ser_sel |=> !ser_drive);                                     // R11
    AST_DOUT_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk) && !$past(rst)) |-> $stable(ser_dout)); // R2
endmodule

bind tw_serial_mem tw_checks i_checks (
    .clk (clk), .rst (rst), .ser_sel (ser_sel), .ser_clk (ser_clk),
    .ser_dout (ser_dout), .ser_drive (ser_drive), .ram_ce_n (ram_ce_n),
    .ram_oe_n (ram_oe_n), .ram_we_n (ram_we_n), .ram_addr (ram_addr)
);

// File: tb/test_tw_serial_mem.sv
module test_tw_serial_mem;
    logic        clk = 1'b0;
    logic        rst, ser_sel, ser_clk, ser_din, hdr_crc_ok;
    logic [7:0]  crc_value;
    logic        ser_dout, ser_drive, ram_ce_n, ram_oe_n, ram_we_n;
    logic [18:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;

    int n_tests = 0, n_fail = 0;
    int acc_cnt = 0, wr_cnt = 0, strobe_bad = 0;
    bit finished = 0;

    logic [7:0] env_mem [logic [18:0]];
    logic [7:0] exp_mem [logic [18:0]];

    always #4 clk = ~clk;

    tw_serial_mem i_tw_serial_mem (
        .clk (clk), .rst (rst), .ser_sel (ser_sel), .ser_clk (ser_clk),
        .ser_din (ser_din), .ser_dout (ser_dout), .ser_drive (ser_drive),
        .hdr_crc_ok (hdr_crc_ok), .crc_value (crc_value),
        .ram_ce_n (ram_ce_n), .ram_oe_n (ram_oe_n), .ram_we_n (ram_we_n),
        .ram_addr (ram_addr), .ram_wdata (ram_wdata), .ram_rdata (ram_rdata)
    );

    function automatic logic [7:0] pat(logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {a[18:16], 5'h0B};
    endfunction

    function automatic logic [7:0] env_rd(logic [18:0] a);
        return env_mem.exists(a) ? env_mem[a] : pat(a);
    endfunction

    function automatic logic [7:0] exp_rd(logic [18:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : pat(a);
    endfunction

    // simple RAM model
    always @(negedge clk) ram_rdata <= env_rd(ram_addr);
    always @(posedge clk) begin
        if (!rst && !ram_ce_n) acc_cnt++;
        if (!rst && !ram_ce_n && !ram_we_n) begin
            env_mem[ram_addr] = ram_wdata;
            wr_cnt++;
        end
        if (!rst && !ram_oe_n && !ram_we_n) strobe_bad++;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic din, output logic dq, output logic drv);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        dq  = ser_dout;
        drv = ser_drive;
        ser_din = din;
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic begin_tr();
        ser_sel = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic end_tr();
        ser_sel = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // sends header; returns number of bit times in which drive was seen high
    task automatic send_hdr(input logic [7:0] fn, input logic [18:0] a,
                            input logic [4:0] cmd, input logic [15:0] id,
                            output int drv_hits);
        logic [55:0] h;
        logic dq, drv;
        h = {8'h00, id, cmd, a[18:16], a[15:0], fn};
        drv_hits = 0;
        for (int i = 0; i < 56; i++) begin
            bit_cycle(h[i], dq, drv);
            if (drv) drv_hits++;
        end
    endtask

    task automatic rd_byte(output logic [7:0] b, output int drv_hits);
        logic dq, drv;
        drv_hits = 0;
        for (int i = 0; i < 8; i++) begin
            bit_cycle(1'b0, dq, drv);
            b[i] = dq;
            if (drv) drv_hits++;
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        logic dq, drv;
        for (int i = 0; i < 8; i++) bit_cycle(b[i], dq, drv);
    endtask

    task automatic burst_read(string req, input logic [18:0] a, input int n,
                              input logic [4:0] cmd, input logic [15:0] id);
        logic [7:0] b;
        int dh;
        begin_tr();
        send_hdr(8'hE8, a, cmd, id, dh);
        chk({req, " no drive in header"}, dh, 0);
        for (int k = 0; k < n; k++) begin
            rd_byte(b, dh);
            chk({req, " read data"}, b, exp_rd(19'(a + 19'(k))));
            chk({req, " drive while sending"}, dh, 8);
        end
        end_tr();
    endtask

    task automatic burst_write(input logic [18:0] a, input int n,
                               input logic [15:0] id, input bit expect_ok);
        logic [7:0] b;
        int dh;
        begin_tr();
        send_hdr(8'h17, a, 5'b10001, id, dh);
        for (int k = 0; k < n; k++) begin
            b = 8'($urandom);
            wr_byte(b);
            if (expect_ok) exp_mem[19'(a + 19'(k))] = b;
        end
        end_tr();
    endtask

    // transaction that must do nothing
    task automatic silent(string req, input logic [7:0] fn, input logic [4:0] cmd,
                          input logic [15:0] id);
        logic [7:0] b;
        int dh, a0, d0;
        a0 = acc_cnt;
        begin_tr();
        send_hdr(fn, 19'h00500, cmd, id, d0);
        rd_byte(b, dh);
        end_tr();
        chk({req, " no RAM access"}, acc_cnt - a0, 0);
        chk({req, " no drive"}, dh + d0, 0);
    endtask

    task automatic read_ident(string req, input logic [15:0] exp);
        logic [7:0] lo, hi, b;
        int d1, d2, d3;
        begin_tr();
        send_hdr(8'hE8, 19'h0, 5'b00101, 16'h0, d1);
        rd_byte(lo, d1);
        rd_byte(hi, d2);
        rd_byte(b, d3);
        end_tr();
        chk({req, " identity"}, {hi, lo}, exp);
        chk({req, " drive during identity"}, d1 + d2, 16);
        chk({req, " release after identity"}, d3, 0);
    endtask

    task automatic write_ident(input logic [15:0] id);
        int dh;
        begin_tr();
        send_hdr(8'h17, 19'h0, 5'b01110, id, dh);
        end_tr();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int dh, w0, a0;
        void'($urandom(32'd1234));
        rst = 1'b1; ser_sel = 1'b0; ser_clk = 1'b1; ser_din = 1'b0;
        hdr_crc_ok = 1'b1; crc_value = 8'h5A;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 ce_n", ram_ce_n, 1);
        chk("R1 oe_n", ram_oe_n, 1);
        chk("R1 we_n", ram_we_n, 1);
        chk("R1 drive", ser_drive, 0);
        read_ident("R1 R8 reset identity", 16'h0000);

        // R5 R2 burst read, then wrap
        burst_read("R5 R2", 19'h12345, 3, 5'b00110, 16'h7777);
        burst_read("R5 wrap", 19'h7FFFF, 2, 5'b00110, 16'h0);

        // R8 identity write and read back
        write_ident(16'hA5C3);
        read_ident("R8", 16'hA5C3);

        // R4 bad check byte
        hdr_crc_ok = 1'b0;
        write_ident(16'h1111);
        silent("R4 read", 8'hE8, 5'b00110, 16'h0);
        hdr_crc_ok = 1'b1;
        read_ident("R4 identity kept", 16'hA5C3);

        // R6 burst write with matching and mismatching identity
        w0 = wr_cnt;
        burst_write(19'h00100, 3, 16'hA5C3, 1);
        chk("R6 write count", wr_cnt - w0, 3);
        burst_read("R6 readback", 19'h00100, 3, 5'b00110, 16'h0);
        w0 = wr_cnt;
        burst_write(19'h00200, 2, 16'hA5C2, 0);
        chk("R6 mismatch no write", wr_cnt - w0, 0);
        burst_read("R6 mismatch data", 19'h00200, 2, 5'b00110, 16'h0);

        // R3 bad function bytes
        silent("R3 bad fn", 8'h55, 5'b00110, 16'hA5C3);
        silent("R3 near fn", 8'hE9, 5'b00110, 16'hA5C3);

        // R9 read check value then release
        begin_tr();
        send_hdr(8'hE8, 19'h0, 5'b00011, 16'h0, dh);
        rd_byte(b, dh);
        chk("R9 check value", b, 8'h5A);
        chk("R9 drive", dh, 8);
        rd_byte(b, dh);
        chk("R9 release", dh, 0);
        end_tr();

        // R10 masked search reads
        burst_read("R10 all masked", 19'h00400, 1, 5'b11000, 16'h0000);
        burst_read("R10 low2 match", 19'h00400, 1, 5'b11001, 16'h0003);
        silent("R10 low2 mismatch", 8'hE8, 5'b11001, 16'h0001);
        burst_read("R10 low14 match", 19'h00400, 1, 5'b11111, 16'h25C3);
        silent("R10 low14 mismatch", 8'hE8, 5'b11111, 16'hA5C1);

        // R7 partial byte discarded, full byte written
        w0 = wr_cnt;
        begin_tr();
        send_hdr(8'h17, 19'h00300, 5'b10001, 16'hA5C3, dh);
        wr_byte(8'h3C);
        for (int i = 0; i < 4; i++) begin
            logic dq, drv;
            bit_cycle(1'b1, dq, drv);
        end
        end_tr();
        exp_mem[19'h00300] = 8'h3C;
        chk("R7 one write", wr_cnt - w0, 1);
        burst_read("R7 data", 19'h00300, 2, 5'b00110, 16'h0);

        // R11 unsupported and cross-coded commands
        silent("R11 arbitration poll", 8'h17, 5'b01001, 16'hA5C3);
        silent("R11 arbitration address", 8'h17, 5'b10110, 16'hA5C3);
        silent("R11 write code as read", 8'hE8, 5'b10001, 16'hA5C3);

        // R11 drop drive when select falls mid byte
        begin_tr();
        send_hdr(8'hE8, 19'h00010, 5'b00110, 16'h0, dh);
        rd_byte(b, dh);
        begin
            logic dq, drv;
            bit_cycle(1'b0, dq, drv);
        end
        ser_sel = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 drive after deselect", ser_drive, 0);
        end_tr();

        // random mix
        for (int t = 0; t < 16; t++) begin
            logic [18:0] a;
            int n;
            a = 19'($urandom);
            if (t % 4 == 0) a = 19'h7FFFE;
            n = 1 + int'($urandom % 3);
            if ($urandom % 2) begin
                w0 = wr_cnt;
                burst_write(a, n, 16'hA5C3, 1);
                chk("R6 random write count", wr_cnt - w0, n);
            end
            burst_read("R5 random", a, n, 5'b00110, 16'($urandom));
        end

        a0 = strobe_bad;
        chk("R12 strobe overlap", a0, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule